// File: doc/BRIEF.md
# Interrupt Collector and Idle-Halt Controller

This block merges the event sources of a keypad companion device into one latched interrupt code and an active-low interrupt request line for the host. A new key event, an error condition, and either edge on one of two general-purpose pins can raise the request. Each pin raises it only while the host has enabled that pin as an interrupt. The request line stays low until the host reads the code. That read returns every pending source bit and clears them all in the same cycle.

The same block watches for inactivity. A prescaler divides the clock into ticks, and an 8-bit host-programmable limit, counted in those ticks, sets how long the device may stay idle. Any activity restarts the count. Activity here means a key event, a bus transaction, a key or special-function line going low, or an enabled pin edge. When the limit is reached and no interrupt is pending, the controller moves to a halt state, and a pending interrupt holds it active. Bus activity, a falling key line or an enabled pin edge brings it back. Gating the clock itself and scanning the keypad are left to neighbouring blocks.

Top module: `irq_halt_ctrl`

## Requirements
- R1: After reset the interrupt code is 0, `irq_n_o` is 1, `halt_o` is 0, both pin enables are 0 and the idle limit equals `IDLE_RESET`.
- R2: A pulse on `key_evt_i` sets code bit 0 and a pulse on `err_evt_i` sets code bit 1 at the same clock edge. `irq_n_o` is 0 after that edge and stays 0 while any code bit is 1.
- R3: When pin enable bit i (`en_wdata_i[i]`, i = 0 or 1) is set, a rising or falling change on `gpio_i[i]` sets code bit 2+i at the third rising edge that samples the new level. With the enable clear, the change leaves the code unchanged.
- R4: A read pulse on `code_rd_i` presents the pending code on `code_o` during that cycle. At that edge every code bit is cleared and `irq_n_o` returns to 1.
- R5: A source event in the same cycle as a read is held in the code after the read.
- R6: With the code clear and no activity, `halt_o` rises P*TICK_DIV+1 edges after the last activity edge, where P is the idle limit.
- R7: Every activity pulse restarts the idle count from zero.
- R8: While any code bit is 1, the controller stays active. Once the code is read clear and the idle time has elapsed, `halt_o` rises at the edge after the read.
- R9: In halt, a pulse on `bus_act_i` clears `halt_o` at that edge. A key line in `wake_n_i` falling, or an enabled pin changing, clears `halt_o` at the third edge that samples the new level. A key line rising, or a change on a disabled pin, leaves the controller halted.
- R10: A write pulse on `idle_we_i` loads `idle_wdata_i` as the new idle limit, and a write pulse on `en_we_i` loads `en_wdata_i` as the pin enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_evt_i | input | 1 | One-cycle pulse: new key event from the scanner |
| err_evt_i | input | 1 | One-cycle pulse: error condition |
| gpio_i | input | 2 | Asynchronous general-purpose pin levels |
| wake_n_i | input | NUM_WAKE | Asynchronous key/special-function lines, low when pressed |
| bus_act_i | input | 1 | One-cycle pulse: host bus activity |
| en_we_i | input | 1 | Write strobe for the pin interrupt enables |
| en_wdata_i | input | 2 | Pin interrupt enables, bit i for pin i |
| idle_we_i | input | 1 | Write strobe for the idle limit |
| idle_wdata_i | input | IDLE_W | Idle limit in prescaled ticks |
| code_rd_i | input | 1 | One-cycle pulse: host reads and clears the code |
| code_o | output | 8 | Interrupt code: bit0 key, bit1 error, bit2 pin 0, bit3 pin 1 |
| irq_n_o | output | 1 | Active-low interrupt request |
| halt_o | output | 1 | 1 while in the halt state |

## Verification
The bench sweeps every idle limit from 0 to 6 and measures the exact halt edge. A prescaler that is off by one, or a comparison that is strict, shifts that edge. It also sweeps all four enable masks with both pins toggling, which exposes a swapped or ignored enable. An event that coincides with a read is checked, because a design that clears the code after merging would drop that event. Halt is checked while the code is pending, and after a read that clears it, to catch a design that halts with an interrupt outstanding. Wake is checked for bus, falling-line and pin sources at their exact edges. Rising key lines and disabled pins are also applied in halt and must leave it halted.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    localparam int SRC_N    = 4;
    localparam int CODE_W   = 8;
    localparam int GPIO_N   = 2;

    typedef enum logic {
        ST_ACTIVE = 1'b0,
        ST_HALT   = 1'b1
    } pwr_state_e;

    // bit 0 key, bit 1 error, bit 2 pin 0, bit 3 pin 1
    typedef struct packed {
        logic gpio1;
        logic gpio0;
        logic err;
        logic key;
    } irq_src_t;

    function automatic logic [CODE_W-1:0] code_byte(irq_src_t s);
        return {{(CODE_W-SRC_N){1'b0}}, s};
    endfunction

endpackage

// File: rtl/irqh_sync.sv
module irqh_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= {W{RST_VAL}};
            s2_q <= {W{RST_VAL}};
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/irqh_edge.sv
module irqh_edge #(
    parameter int   W         = 1,
    parameter logic RST_VAL   = 1'b0,
    parameter bit   FALL_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= {W{RST_VAL}};
        else     prev_q <= d_i;
    end

    generate
        if (FALL_ONLY) begin : g_fall
            assign evt_o = prev_q & ~d_i;
        end else begin : g_both
            assign evt_o = prev_q ^ d_i;
        end
    endgenerate
endmodule

// File: rtl/irqh_code.sv
module irqh_code
    import irqh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_src_t set_i,
    input  logic     rd_i,
    output irq_src_t code_o,
    output logic     irq_n_o
);
    logic [SRC_N-1:0] set_v, code_q, code_d;
    logic             irq_n_q;

    assign set_v = set_i;

    // A read clears everything pending, but a same-cycle arrival survives.
    always_comb begin
        if (rd_i) code_d = set_v;
        else      code_d = code_q | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            irq_n_q <= 1'b1;
        end else begin
            code_q  <= code_d;
            irq_n_q <= ~(|code_d);
        end
    end

    assign code_o  = irq_src_t'(code_q);
    assign irq_n_o = irq_n_q;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_i && set_v == '0) |=> (code_q == '0));  // R4

    AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((code_q & $past(set_v)) == $past(set_v)));  // R5

    AST_NO_SPURIOUS_BIT: assert property (@(posedge clk) disable iff (rst)
        (|(code_q & ~$past(code_q))) |-> (|$past(set_v)));  // R2

    AST_IRQ_TRACKS_CODE: assert property (@(posedge clk) disable iff (rst)
        irq_n_o == (code_q == '0));  // R2
endmodule

// File: rtl/irqh_idle.sv
module irqh_idle
    import irqh_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int IDLE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_i,
    input  logic              pend_i,
    input  logic [IDLE_W-1:0] lim_i,
    output logic              halt_o
);
    localparam int              PW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0]   PRE_LAST = PW'(TICK_DIV - 1);
    localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

    logic [PW-1:0]     pre_q;
    logic [IDLE_W-1:0] idle_q;
    pwr_state_e        st_q;
    logic              tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            idle_q <= '0;
            st_q   <= ST_ACTIVE;
        end else if (act_i) begin
            pre_q  <= '0;
            idle_q <= '0;
            st_q   <= ST_ACTIVE;
        end else if (st_q == ST_ACTIVE) begin
            if (tick) begin
                pre_q <= '0;
                if (idle_q != IDLE_MAX) idle_q <= idle_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
            if (!pend_i && idle_q >= lim_i) st_q <= ST_HALT;
        end
    end

    assign halt_o = (st_q == ST_HALT);

    AST_PEND_BLOCKS_HALT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACTIVE && pend_i) |=> (st_q == ST_ACTIVE));  // R8

    AST_ACT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        act_i |=> (idle_q == '0 && pre_q == '0));  // R7

    AST_WAKE_ON_ACT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && act_i) |=> (st_q == ST_ACTIVE));  // R9

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && !act_i) |=> $stable(idle_q));  // R6
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
    import irqh_pkg::*;
#(
    parameter int NUM_WAKE   = 8,
    parameter int TICK_DIV   = 4,
    parameter int IDLE_W     = 8,
    parameter int IDLE_RESET = 125
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                key_evt_i,
    input  logic                err_evt_i,
    input  logic [1:0]          gpio_i,
    input  logic [NUM_WAKE-1:0] wake_n_i,
    input  logic                bus_act_i,
    input  logic                en_we_i,
    input  logic [1:0]          en_wdata_i,
    input  logic                idle_we_i,
    input  logic [IDLE_W-1:0]   idle_wdata_i,
    input  logic                code_rd_i,
    output logic [7:0]          code_o,
    output logic                irq_n_o,
    output logic                halt_o
);
    logic [GPIO_N-1:0]   en_q;
    logic [IDLE_W-1:0]   lim_q;
    logic [GPIO_N-1:0]   gpio_s, gpio_chg, gpio_evt;
    logic [NUM_WAKE-1:0] wake_s, wake_fall;
    irq_src_t            set_s, code_s;
    logic                act;

    // host-written configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lim_q <= IDLE_W'(IDLE_RESET);
        end else begin
            if (en_we_i)   en_q  <= en_wdata_i;
            if (idle_we_i) lim_q <= idle_wdata_i;
        end
    end

    irqh_sync #(.W(GPIO_N), .RST_VAL(1'b0)) u_gpio_sync (
        .clk(clk), .rst(rst), .d_i(gpio_i), .q_o(gpio_s)
    );
    irqh_edge #(.W(GPIO_N), .RST_VAL(1'b0), .FALL_ONLY(1'b0)) u_gpio_edge (
        .clk(clk), .rst(rst), .d_i(gpio_s), .evt_o(gpio_chg)
    );

    irqh_sync #(.W(NUM_WAKE), .RST_VAL(1'b1)) u_wake_sync (
        .clk(clk), .rst(rst), .d_i(wake_n_i), .q_o(wake_s)
    );
    irqh_edge #(.W(NUM_WAKE), .RST_VAL(1'b1), .FALL_ONLY(1'b1)) u_wake_edge (
        .clk(clk), .rst(rst), .d_i(wake_s), .evt_o(wake_fall)
    );

    assign gpio_evt = gpio_chg & en_q;

    always_comb begin
        set_s.key   = key_evt_i;
        set_s.err   = err_evt_i;
        set_s.gpio0 = gpio_evt[0];
        set_s.gpio1 = gpio_evt[1];
    end

    assign act = key_evt_i | bus_act_i | (|wake_fall) | (|gpio_evt);

    irqh_code u_code (
        .clk(clk), .rst(rst), .set_i(set_s), .rd_i(code_rd_i),
        .code_o(code_s), .irq_n_o(irq_n_o)
    );

    irqh_idle #(.TICK_DIV(TICK_DIV), .IDLE_W(IDLE_W)) u_idle (
        .clk(clk), .rst(rst), .act_i(act), .pend_i(code_s != '0),
        .lim_i(lim_q), .halt_o(halt_o)
    );

    assign code_o = code_byte(code_s);

    AST_DISABLED_PIN_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!en_q[0] && !code_o[2] && !code_rd_i) |=> !code_o[2]);  // R3
endmodule

// File: tb/irq_halt_ctrl_test.sv
`timescale 1ns/1ps
module irq_halt_ctrl_test;
    localparam int D  = 4;
    localparam int IR = 5;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          key_evt = 0, err_evt = 0, bus_act = 0;
    logic [1:0]    gpio = 2'b00;
    logic [NW-1:0] wake_n = '1;
    logic          en_we = 0, idle_we = 0, code_rd = 0;
    logic [1:0]    en_wdata = 0;
    logic [7:0]    idle_wdata = 0;
    logic [7:0]    code;
    logic          irq_n, halt;

    int checks = 0, fails = 0;
    bit done = 0;

    irq_halt_ctrl #(.NUM_WAKE(NW), .TICK_DIV(D), .IDLE_W(8), .IDLE_RESET(IR)) uut (
        .clk(clk), .rst(rst), .key_evt_i(key_evt), .err_evt_i(err_evt),
        .gpio_i(gpio), .wake_n_i(wake_n), .bus_act_i(bus_act),
        .en_we_i(en_we), .en_wdata_i(en_wdata), .idle_we_i(idle_we),
        .idle_wdata_i(idle_wdata), .code_rd_i(code_rd), .code_o(code),
        .irq_n_o(irq_n), .halt_o(halt)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bus();
        @(negedge clk); bus_act = 1;
        @(negedge clk); bus_act = 0;
    endtask

    task automatic pulse_key();
        @(negedge clk); key_evt = 1;
        @(negedge clk); key_evt = 0;
    endtask

    task automatic pulse_err();
        @(negedge clk); err_evt = 1;
        @(negedge clk); err_evt = 0;
    endtask

    task automatic read_code(output logic [7:0] v);
        @(negedge clk); code_rd = 1; v = code;
        @(negedge clk); code_rd = 0;
    endtask

    task automatic set_idle(input int p);
        @(negedge clk); idle_we = 1; idle_wdata = 8'(p);
        @(negedge clk); idle_we = 0;
    endtask

    task automatic set_en(input logic [1:0] m);
        @(negedge clk); en_we = 1; en_wdata = m;
        @(negedge clk); en_we = 0;
    endtask

    // counts edges after the last activity edge until halt rises
    task automatic measure_halt(input int exp, input string req);
        int n = 0;
        while (!halt && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp, req, "edges to halt", n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        wait_n(3);
        chk(code == 0, "R1", "code after reset", code, 0);
        chk(irq_n == 1, "R1", "irq_n after reset", irq_n, 1);
        chk(halt == 0, "R1", "halt after reset", halt, 0);

        // default idle limit, counted from a bus pulse on the first free edge
        @(negedge clk); rst = 0; bus_act = 1;
        @(negedge clk); bus_act = 0;
        measure_halt(IR * D + 1, "R1");

        // R6 / R10: sweep the idle limit
        for (int p = 0; p <= 6; p++) begin
            set_idle(p);
            pulse_bus();
            measure_halt(p * D + 1, "R6");
        end

        // R7: a second activity restarts the count
        set_idle(2);
        pulse_bus();
        wait_n(5);
        chk(halt == 0, "R7", "halt before restart", halt, 0);
        pulse_bus();
        measure_halt(2 * D + 1, "R7");

        // R2 / R8 / R4
        set_idle(1);
        pulse_bus();
        pulse_key();
        chk(code == 8'h01, "R2", "key bit", code, 1);
        chk(irq_n == 0, "R2", "irq_n on key", irq_n, 0);
        pulse_err();
        chk(code == 8'h03, "R2", "error bit", code, 3);
        wait_n(30);
        chk(halt == 0, "R8", "halt while pending", halt, 0);
        chk(irq_n == 0, "R2", "irq_n held", irq_n, 0);
        read_code(v);
        chk(v == 8'h03, "R4", "read value", v, 3);
        chk(code == 0, "R4", "code cleared", code, 0);
        chk(irq_n == 1, "R4", "irq_n released", irq_n, 1);
        chk(halt == 0, "R8", "halt at read edge", halt, 0);
        @(negedge clk);
        chk(halt == 1, "R8", "halt after read", halt, 1);

        // R5: event coinciding with a read is kept
        pulse_bus();
        pulse_key();
        @(negedge clk); code_rd = 1; err_evt = 1; v = code;
        @(negedge clk); code_rd = 0; err_evt = 0;
        chk(v == 8'h01, "R5", "read value", v, 1);
        chk(code == 8'h02, "R5", "kept event", code, 2);
        chk(irq_n == 0, "R5", "irq_n kept", irq_n, 0);
        read_code(v);
        chk(v == 8'h02, "R5", "second read", v, 2);

        // R3: exact pin timing, rising then falling
        set_idle(40);
        set_en(2'b01);
        pulse_bus();
        @(negedge clk); gpio[0] = 1;
        @(negedge clk); chk(code == 0, "R3", "pin rise +1", code, 0);
        @(negedge clk); chk(code == 0, "R3", "pin rise +2", code, 0);
        @(negedge clk); chk(code == 8'h04, "R3", "pin rise +3", code, 4);
        read_code(v);
        @(negedge clk); gpio[0] = 0;
        wait_n(3);
        chk(code == 8'h04, "R3", "pin fall", code, 4);
        read_code(v);
        @(negedge clk); gpio[1] = 1;
        wait_n(5);
        chk(code == 0, "R3", "disabled pin", code, 0);

        // R3: all enable masks with both pins toggling
        for (int m = 0; m < 4; m++) begin
            set_en(2'(m));
            @(negedge clk); gpio = ~gpio;
            wait_n(4);
            chk(code == 8'(m << 2), "R3", "mask sweep", code, m << 2);
            read_code(v);
        end

        // R9: wake sources
        set_idle(0);
        set_en(2'b00);
        wait_n(2);
        chk(halt == 1, "R9", "halted", halt, 1);
        @(negedge clk); gpio[0] = ~gpio[0];
        wait_n(5);
        chk(halt == 1, "R9", "disabled pin no wake", halt, 1);
        chk(code == 0, "R9", "disabled pin no code", code, 0);
        @(negedge clk); wake_n[2] = 0;
        @(negedge clk); chk(halt == 1, "R9", "fall +1", halt, 1);
        @(negedge clk); chk(halt == 1, "R9", "fall +2", halt, 1);
        @(negedge clk); chk(halt == 0, "R9", "fall +3 wakes", halt, 0);
        @(negedge clk); chk(halt == 1, "R9", "re-halt", halt, 1);
        @(negedge clk); wake_n[2] = 1;
        wait_n(5);
        chk(halt == 1, "R9", "rising line no wake", halt, 1);
        pulse_bus();
        chk(halt == 0, "R9", "bus wakes", halt, 0);
        @(negedge clk); chk(halt == 1, "R9", "re-halt after bus", halt, 1);
        set_en(2'b10);
        @(negedge clk); gpio[1] = ~gpio[1];
        wait_n(3);
        chk(halt == 0, "R9", "enabled pin wakes", halt, 0);
        chk(code == 8'h08, "R9", "pin 1 code", code, 8);
        read_code(v);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule